// File: doc/BRIEF.md
# Bus Transaction Address Trap Capture

This block watches a simplified host-bus transaction stream and checks each completed transaction against two programmable trap windows, numbered 0 and 1. Each window has a base address, a per-bit ignore mask and a space type, either I/O or memory. Each window also has its own read-capture enable and write-capture enable. When a completed transaction falls inside a window, is in that window's space, and the enable for its direction is set, the block latches the transaction's address, data, byte enables and command into shared capture registers. It also raises a sticky valid flag.

Software programs the windows and reads the capture through a simple register port. Register writes take effect on the clock edge. Reads are combinational. The captured values stay frozen until software clears the valid flag. Per-window and global system-management trap enable bits are stored and read back, but they have no influence on capture.

Register map, indexed by `regAddr`:

| Index | Contents |
|---|---|
| 0 | window 0 base |
| 1 | window 0 mask |
| 2 | window 0 control |
| 3 | window 1 base |
| 4 | window 1 mask |
| 5 | window 1 control |
| 6 | captured address |
| 7 | captured data |
| 8 | capture status |
| 9 | global control |

Control bits in registers 2 and 5:

| Bit | Meaning |
|---|---|
| 0 | read-capture enable |
| 1 | write-capture enable |
| 2 | space, 1 = I/O and 0 = memory |
| 4 | per-window management trap enable |

Register 9 bit 0 is the global management trap enable.

Top module: `bus_trap_capture`

## Requirements
- R1: After reset every configuration register and capture register reads 0, so no transaction is captured until software sets a capture enable.
- R2: A window matches when every address bit whose mask bit is 0 equals the corresponding base bit; address bits whose mask bit is 1 are ignored.
- R3: A window matches only if `txnIsIo` equals its control bit 2 (1 = I/O, 0 = memory).
- R4: Command bit 0 selects the direction, with 0 meaning read and 1 meaning write. A read is captured only when control bit 0 of the matching window is set, and a write only when control bit 1 is set.
- R5: A capture happens on the clock edge at which `txnDone` is high. From the next clock, register 6 holds the address and register 7 holds the data. Register 8 holds the command in bits 3:0, the byte enables in bits 7:4, the hitting window number in bit 8 and the valid flag in bit 16.
- R6: Once the valid flag is set, later qualifying transactions leave registers 6, 7 and 8 unchanged.
- R7: Writing register 8 with bit 16 set clears the valid flag. Writing it with bit 16 clear has no effect.
- R8: When both windows qualify, meaning they match and are enabled for the direction, window 0 is recorded. If only window 1 qualifies, window 1 is recorded.
- R9: The management trap enables (control bit 4 of each window and register 9 bit 0) have no effect on capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnDone | input | 1 | Data phase of the current transaction completes this cycle |
| txnAddr | input | ADDR_W | Transaction address |
| txnData | input | DATA_W | Transaction data |
| txnByteEn | input | BE_W | Transaction byte enables |
| txnCmd | input | 4 | Bus command; bit 0 = 1 means write |
| txnIsIo | input | 1 | 1 = I/O space, 0 = memory space |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |

## Verification
A capture is registered on the edge where `txnDone` is high, so each capture register is due one clock later. The bench drives every transaction on a falling edge, keeps it for one rising edge, and reads registers 6 to 8 at the following falling edge. Register writes, including the valid clear, are likewise checked one falling edge after the rising edge that commits them. Checks that expect no capture read the same registers at the same point and compare them against the frozen values held in the scoreboard.

// File: rtl/trap_cap_pkg.sv
package trap_cap_pkg;
  localparam int NUM_WIN = 2;
  localparam int REG_W   = 32;
  localparam int REG_AW  = 4;

  localparam logic [REG_AW-1:0] IDX_W0_BASE = 4'd0;
  localparam logic [REG_AW-1:0] IDX_W0_MASK = 4'd1;
  localparam logic [REG_AW-1:0] IDX_W0_CTL  = 4'd2;
  localparam logic [REG_AW-1:0] IDX_W1_BASE = 4'd3;
  localparam logic [REG_AW-1:0] IDX_W1_MASK = 4'd4;
  localparam logic [REG_AW-1:0] IDX_W1_CTL  = 4'd5;
  localparam logic [REG_AW-1:0] IDX_CAP_ADR = 4'd6;
  localparam logic [REG_AW-1:0] IDX_CAP_DAT = 4'd7;
  localparam logic [REG_AW-1:0] IDX_CAP_STS = 4'd8;
  localparam logic [REG_AW-1:0] IDX_GLOBAL  = 4'd9;

  localparam int CTL_BITS   = 5;
  localparam int VALID_BIT  = 16;
  localparam int WIN_BIT    = 8;

  typedef struct packed {
    logic capture;
    logic winSel;
    logic clearValid;
  } trapStrobes_t;
endpackage

// File: rtl/trap_window_match.sv
module trap_window_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] ignoreMask,
  input  logic              rdEnable,
  input  logic              wrEnable,
  input  logic              spaceIo,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic              txnIsIo,
  input  logic              isWrite,
  output logic              qualHit
);
  logic addrMatch;
  logic dirEnabled;

  always_comb begin
    addrMatch  = (((txnAddr ^ baseAddr) & ~ignoreMask) == '0);
    dirEnabled = isWrite ? wrEnable : rdEnable;
    qualHit    = addrMatch && (txnIsIo == spaceIo) && dirEnabled;
  end
endmodule

// File: rtl/trap_cap_ctrl.sv
module trap_cap_ctrl
  import trap_cap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                              txnDone,
  input  logic [ADDR_W-1:0]                 txnAddr,
  input  logic                              txnWriteBit,
  input  logic                              txnIsIo,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]    winBase,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]    winMask,
  input  logic [NUM_WIN-1:0][2:0]           winCtl,
  input  logic                              capValid,
  input  logic                              regWrEn,
  input  logic [REG_AW-1:0]                 regAddr,
  input  logic                              clearBit,
  output trapStrobes_t                      strb
);
  logic [NUM_WIN-1:0] qualHit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
    trap_window_match #(.ADDR_W(ADDR_W)) uMatch (
      .baseAddr  (winBase[w]),
      .ignoreMask(winMask[w]),
      .rdEnable  (winCtl[w][0]),
      .wrEnable  (winCtl[w][1]),
      .spaceIo   (winCtl[w][2]),
      .txnAddr   (txnAddr),
      .txnIsIo   (txnIsIo),
      .isWrite   (txnWriteBit),
      .qualHit   (qualHit[w])
    );
  end

  always_comb begin
    strb            = '0;
    strb.capture    = txnDone && (|qualHit) && !capValid;
    strb.winSel     = !qualHit[0];
    strb.clearValid = regWrEn && (regAddr == IDX_CAP_STS) && clearBit;
  end
endmodule

// File: rtl/trap_cap_datapath.sv
module trap_cap_datapath
  import trap_cap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  trapStrobes_t                   strb,
  input  logic [ADDR_W-1:0]              txnAddr,
  input  logic [DATA_W-1:0]              txnData,
  input  logic [BE_W-1:0]                txnByteEn,
  input  logic [3:0]                     txnCmd,
  input  logic                           regWrEn,
  input  logic [REG_AW-1:0]              regAddr,
  input  logic [REG_W-1:0]               regWrData,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] winBase,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] winMask,
  output logic [NUM_WIN-1:0][2:0]        winCtl,
  output logic                           capValid,
  output logic [ADDR_W-1:0]              capAddr,
  output logic [REG_W-1:0]               regRdData
);
  localparam int STS_W = 4 + BE_W;

  logic [NUM_WIN-1:0][CTL_BITS-1:0] ctlQ;
  logic                             globalQ;
  logic [DATA_W-1:0]                capData;
  logic [STS_W-1:0]                 capCmdBe;
  logic                             capWin;

  for (genvar w = 0; w < NUM_WIN; w++) begin : gCfg
    localparam logic [REG_AW-1:0] BASE_IDX = REG_AW'(3 * w);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        winBase[w] <= '0;
        winMask[w] <= '0;
        ctlQ[w]    <= '0;
      end else if (regWrEn) begin
        if (regAddr == BASE_IDX)              winBase[w] <= regWrData[ADDR_W-1:0];
        if (regAddr == BASE_IDX + 4'd1)       winMask[w] <= regWrData[ADDR_W-1:0];
        if (regAddr == BASE_IDX + 4'd2)       ctlQ[w]    <= regWrData[CTL_BITS-1:0];
      end
    end
    assign winCtl[w] = ctlQ[w][2:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalQ <= 1'b0;
    end else if (regWrEn && regAddr == IDX_GLOBAL) begin
      globalQ <= regWrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capValid <= 1'b0;
      capAddr  <= '0;
      capData  <= '0;
      capCmdBe <= '0;
      capWin   <= 1'b0;
    end else if (strb.capture) begin
      capValid <= 1'b1;
      capAddr  <= txnAddr;
      capData  <= txnData;
      capCmdBe <= {txnByteEn, txnCmd};
      capWin   <= strb.winSel;
    end else if (strb.clearValid) begin
      capValid <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      IDX_W0_BASE: regRdData = REG_W'(winBase[0]);
      IDX_W0_MASK: regRdData = REG_W'(winMask[0]);
      IDX_W0_CTL:  regRdData = REG_W'(ctlQ[0]);
      IDX_W1_BASE: regRdData = REG_W'(winBase[1]);
      IDX_W1_MASK: regRdData = REG_W'(winMask[1]);
      IDX_W1_CTL:  regRdData = REG_W'(ctlQ[1]);
      IDX_CAP_ADR: regRdData = REG_W'(capAddr);
      IDX_CAP_DAT: regRdData = REG_W'(capData);
      IDX_CAP_STS: begin
        regRdData[STS_W-1:0]  = capCmdBe;
        regRdData[WIN_BIT]    = capWin;
        regRdData[VALID_BIT]  = capValid;
      end
      IDX_GLOBAL:  regRdData = REG_W'(globalQ);
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/bus_trap_capture.sv
module bus_trap_capture
  import trap_cap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnDone,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic [DATA_W-1:0] txnData,
  input  logic [BE_W-1:0]   txnByteEn,
  input  logic [3:0]        txnCmd,
  input  logic              txnIsIo,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData
);
  trapStrobes_t                   strb;
  logic [NUM_WIN-1:0][ADDR_W-1:0] winBase;
  logic [NUM_WIN-1:0][ADDR_W-1:0] winMask;
  logic [NUM_WIN-1:0][2:0]        winCtl;
  logic                           capValid;
  logic [ADDR_W-1:0]              capAddr;

  trap_cap_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .txnDone    (txnDone),
    .txnAddr    (txnAddr),
    .txnWriteBit(txnCmd[0]),
    .txnIsIo    (txnIsIo),
    .winBase    (winBase),
    .winMask    (winMask),
    .winCtl     (winCtl),
    .capValid   (capValid),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .clearBit   (regWrData[VALID_BIT]),
    .strb       (strb)
  );

  trap_cap_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .txnAddr  (txnAddr),
    .txnData  (txnData),
    .txnByteEn(txnByteEn),
    .txnCmd   (txnCmd),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .winBase  (winBase),
    .winMask  (winMask),
    .winCtl   (winCtl),
    .capValid (capValid),
    .capAddr  (capAddr),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/trap_cap_checker.sv
module trap_cap_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              txnDone,
  input logic [ADDR_W-1:0] txnAddr,
  input logic              regWrEn,
  input logic [3:0]        regAddr,
  input logic [31:0]       regWrData,
  input logic              capValid,
  input logic [ADDR_W-1:0] capAddr,
  input logic              capture
);
  logic clearWrite;
  assign clearWrite = regWrEn && (regAddr == 4'd8) && regWrData[16];

  AST_CAPTURE_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> (capValid && capAddr == $past(txnAddr))); // R5

  AST_VALID_FROM_TXN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capValid) |-> $past(txnDone)); // R5

  AST_FROZEN_WHILE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && !clearWrite) |=> (capValid && $stable(capAddr))); // R6

  AST_CLEAR_ON_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && clearWrite) |=> !capValid); // R7
endmodule

bind bus_trap_capture trap_cap_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .txnDone  (txnDone),
  .txnAddr  (txnAddr),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .capValid (capValid),
  .capAddr  (capAddr),
  .capture  (strb.capture)
);

// File: tb/bus_trap_capture_test.sv
module bus_trap_capture_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txnDone = 1'b0;
  logic [31:0] txnAddr = '0;
  logic [31:0] txnData = '0;
  logic [3:0]  txnByteEn = '0;
  logic [3:0]  txnCmd = '0;
  logic        txnIsIo = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int testsRun = 0;
  int testsFailed = 0;

  typedef struct { logic [31:0] a; logic [31:0] d; logic [31:0] s; } expCap_t;
  expCap_t sbQueue[$];

  logic [31:0] mBase[2];
  logic [31:0] mMask[2];
  logic [31:0] mCtl[2];
  logic        mValid = 1'b0;
  logic [31:0] mA = '0, mD = '0, mS = '0;

  always #2.5 clk = ~clk;

  bus_trap_capture uut (
    .clk(clk), .rstN(rstN), .txnDone(txnDone), .txnAddr(txnAddr),
    .txnData(txnData), .txnByteEn(txnByteEn), .txnCmd(txnCmd),
    .txnIsIo(txnIsIo), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [3:0] idx, output logic [31:0] val);
    regAddr = idx;
    #0.5;
    val = regRdData;
  endtask

  task automatic writeReg(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = idx; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    if (idx <= 4'd5) begin
      case (idx % 3)
        0: mBase[idx/3] = val;
        1: mMask[idx/3] = val;
        default: mCtl[idx/3] = {27'd0, val[4:0]};
      endcase
    end
    if (idx == 4'd8 && val[16]) mValid = 1'b0;
  endtask

  function automatic logic qual(int w, logic [31:0] a, logic [3:0] c, logic io);
    logic en;
    en = c[0] ? mCtl[w][1] : mCtl[w][0];
    return (((a ^ mBase[w]) & ~mMask[w]) == 32'd0) && (io == mCtl[w][2]) && en;
  endfunction

  // Driver: drives one transaction and pushes the expected capture state.
  task automatic busTxn(logic [31:0] a, logic [31:0] d, logic [3:0] be,
                        logic [3:0] c, logic io);
    logic h0, h1;
    expCap_t e;
    @(negedge clk);
    txnDone = 1'b1; txnAddr = a; txnData = d; txnByteEn = be;
    txnCmd = c; txnIsIo = io;
    h0 = qual(0, a, c, io);
    h1 = qual(1, a, c, io);
    if (!mValid && (h0 || h1)) begin
      mValid = 1'b1; mA = a; mD = d;
      mS = {15'd0, 1'b0, 7'd0, !h0, be, c};
    end
    e.a = mA; e.d = mD; e.s = mS | {15'd0, mValid, 16'd0};
    sbQueue.push_back(e);
    @(negedge clk);
    txnDone = 1'b0;
  endtask

  // Monitor: pops the expected item and compares against the capture registers.
  task automatic monitorCheck(string tag);
    expCap_t e;
    logic [31:0] v;
    e = sbQueue.pop_front();
    readReg(4'd6, v); check({tag, " addr"}, v, e.a);
    readReg(4'd7, v); check({tag, " data"}, v, e.d);
    readReg(4'd8, v); check({tag, " status"}, v, e.s);
  endtask

  task automatic clearValid();
    writeReg(4'd8, 32'h0001_0000);
  endtask

  initial begin
    logic [31:0] v;
    for (int w = 0; w < 2; w++) begin mBase[w] = '0; mMask[w] = '0; mCtl[w] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(4'd2, v); check("R1 w0 ctl reset", v, 32'd0);
    readReg(4'd5, v); check("R1 w1 ctl reset", v, 32'd0);
    readReg(4'd8, v); check("R1 status reset", v, 32'd0);
    busTxn(32'h0, 32'h1234, 4'hF, 4'h6, 1'b0);
    monitorCheck("R1 no capture when disabled");

    // R2/R5: basic read capture in window 0
    writeReg(4'd0, 32'h0000_1000);
    writeReg(4'd1, 32'h0000_000F);
    writeReg(4'd2, 32'h1);
    readReg(4'd1, v); check("R2 mask readback", v, 32'hF);
    busTxn(32'h1003, 32'hAABBCCDD, 4'h3, 4'h6, 1'b0);
    monitorCheck("R5 capture w0 read");

    // R6: frozen while valid
    busTxn(32'h1007, 32'h55555555, 4'hC, 4'h6, 1'b0);
    monitorCheck("R6 no overwrite");

    // R7: writing 0 keeps, writing 1 clears
    writeReg(4'd8, 32'h0);
    readReg(4'd8, v); check("R7 zero write keeps valid", v[16], 1'b1);
    clearValid();
    readReg(4'd8, v); check("R7 one write clears", v[16], 1'b0);

    // R4: write not enabled
    busTxn(32'h1003, 32'h1, 4'h1, 4'h7, 1'b0);
    monitorCheck("R4 write blocked");
    // R2: masked-out bit differs
    busTxn(32'h1013, 32'h2, 4'h1, 4'h6, 1'b0);
    monitorCheck("R2 outside window");
    // R3: wrong space
    busTxn(32'h1003, 32'h3, 4'h1, 4'h2, 1'b1);
    monitorCheck("R3 space mismatch");

    // R4/R5: window 1 I/O write
    writeReg(4'd3, 32'h0000_2000);
    writeReg(4'd4, 32'h0);
    writeReg(4'd5, 32'h6);
    busTxn(32'h2000, 32'hCAFE0001, 4'h8, 4'h3, 1'b1);
    monitorCheck("R4 w1 write capture");
    clearValid();
    busTxn(32'h2000, 32'hCAFE0002, 4'h8, 4'h2, 1'b1);
    monitorCheck("R4 w1 read blocked");

    // R8: priority
    writeReg(4'd3, 32'h0000_1000);
    writeReg(4'd4, 32'h0000_00FF);
    writeReg(4'd5, 32'h1);
    busTxn(32'h1004, 32'h44, 4'hF, 4'h6, 1'b0);
    monitorCheck("R8 overlap picks w0");
    clearValid();
    busTxn(32'h1040, 32'h88, 4'hF, 4'h6, 1'b0);
    monitorCheck("R8 only w1 qualifies");
    clearValid();

    // R9: management trap enables have no effect
    writeReg(4'd9, 32'h1);
    writeReg(4'd2, 32'h11);
    readReg(4'd9, v); check("R9 global readback", v, 32'h1);
    busTxn(32'h100A, 32'h99, 4'h5, 4'h6, 1'b0);
    monitorCheck("R9 capture with enables set");
    clearValid();
    writeReg(4'd9, 32'h0);
    writeReg(4'd2, 32'h01);
    busTxn(32'h100B, 32'h9A, 4'h6, 4'h6, 1'b0);
    monitorCheck("R9 capture with enables clear");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule